// File: doc/BRIEF.md
# Level-1 Data Memory Control and Bank Decoder

This block holds the control word for a level-1 data memory and decodes every data access address against it. Software writes the word over a simple register port at a fixed address and can read it back in the same cycle. Three fields matter. One turns lookaside protection checking on or off. One puts data bank A either wholly in SRAM mode or in split mode, with the lower 16 KB as SRAM and the upper 16 KB as cache. One picks which address bit, 14 or 23, selects bank A for cache accesses.

The bank mode is held in a two-state machine with states `MODE_SRAM` and `MODE_CACHE`. A hit write with the configure bit at 1 takes the transition `T_ENTER_CACHE`. A hit write with that bit at 0 while in `MODE_CACHE` takes `T_LEAVE_CACHE`. Any other cycle is `T_HOLD`. Only `T_LEAVE_CACHE` raises a one-cycle invalidate-all request, so the cache contents are thrown away when the bank returns to plain SRAM.

Top module: `dmem_bank_ctrl`

## Requirements
- R1: After reset the control word at address 0xFFE0_0004 reads 0x0000_1001, and `lookaside_en`, `bank_cache_mode`, `bank_sel`, `acc_cacheable` and `inval_all` are all 0.
- R2: `reg_rdata` shows the control word whenever `reg_addr` equals 0xFFE0_0004, and shows 0 for any other address. A write to any other address changes nothing.
- R3: Bit 1 of the control word is the lookaside enable. It is writable, and `lookaside_en` follows it from the cycle after the write.
- R4: Bit 2 is the configure bit: 0 selects SRAM mode and 1 selects cache mode. `bank_cache_mode` shows the mode from the cycle after the write. Bit 3 is reserved and reads 0.
- R5: Bits 0 and 12 always read 1. Every bit other than 1, 2 and 4 ignores writes.
- R6: Bit 4 picks the bank-select address bit: 0 picks `acc_addr[14]` and 1 picks `acc_addr[23]`. In cache mode, `bank_sel` equals the chosen address bit.
- R7: In SRAM mode, `bank_sel` and `acc_cacheable` are 0 for every address, whatever the value of bit 4.
- R8: In cache mode, `acc_cacheable` equals `acc_addr[14]`. This marks the upper 16 KB half of the bank as cache.
- R9: `inval_all` is high for exactly the one cycle after a write that moves the mode from cache to SRAM. A write that leaves SRAM mode at SRAM, or that writes cache mode, gives no pulse.
- R10: A write in the same cycle that `inval_all` is high takes effect normally, and the pulse still lasts only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Single-cycle write strobe |
| reg_addr | input | 32 | Register port address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data |
| acc_addr | input | 32 | Data access address being decoded |
| lookaside_en | output | 1 | Lookaside protection checking enabled |
| bank_cache_mode | output | 1 | Bank A in split SRAM/cache mode |
| bank_sel | output | 1 | Bank A selected for a cache access |
| acc_cacheable | output | 1 | Access falls in the cache half of bank A |
| inval_all | output | 1 | One-cycle invalidate-all request |

## Verification
Two functions can meet in one cycle: the invalidate pulse raised by `T_LEAVE_CACHE`, and a new register write that takes the machine straight back into cache mode. The bench provokes this by leaving cache mode and then issuing an entering write in the very cycle the pulse is high. It then checks three things: the pulse was high in that cycle, it dropped in the next cycle, and the mode and `bank_sel` show cache mode again. The bench also checks that, in the pulse cycle itself, the bank-select and cacheable outputs are already forced low by SRAM mode.

// File: rtl/dmem_ctl_pkg.sv
package dmem_ctl_pkg;

    typedef enum logic [0:0] {
        MODE_SRAM  = 1'b0,
        MODE_CACHE = 1'b1
    } bank_mode_e;

    typedef enum logic [1:0] {
        T_HOLD        = 2'd0,
        T_ENTER_CACHE = 2'd1,
        T_LEAVE_CACHE = 2'd2
    } mode_trans_e;

    localparam int          LAE_POS   = 1;
    localparam int          CFG_POS   = 2;
    localparam int          BSEL_POS  = 4;
    localparam logic [31:0] FIXED_ONE = 32'h0000_1001;

endpackage

// File: rtl/dmem_ctl_regs.sv
module dmem_ctl_regs
    import dmem_ctl_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] CTRL_ADDR = 32'hFFE0_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mode_cache,
    output logic              hit_wr,
    output logic              cfg_bit,
    output logic              lae_q,
    output logic              bsel_q,
    output logic [DATA_W-1:0] rdata
);

    logic hit;

    assign hit     = (addr == CTRL_ADDR[ADDR_W-1:0]);
    assign hit_wr  = wr_en && hit;
    assign cfg_bit = wdata[CFG_POS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lae_q  <= 1'b0;
            bsel_q <= 1'b0;
        end else if (hit_wr) begin
            lae_q  <= wdata[LAE_POS];
            bsel_q <= wdata[BSEL_POS];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata           = FIXED_ONE[DATA_W-1:0];
            rdata[LAE_POS]  = lae_q;
            rdata[CFG_POS]  = mode_cache;
            rdata[BSEL_POS] = bsel_q;
        end
    end

endmodule

// File: rtl/dmem_mode_fsm.sv
module dmem_mode_fsm
    import dmem_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_wr,
    input  logic cfg_bit,
    output logic mode_cache,
    output logic inval
);

    bank_mode_e  state_q, state_d;
    mode_trans_e trans;

    always_comb begin
        trans   = T_HOLD;
        state_d = state_q;
        if (hit_wr) begin
            unique case (state_q)
                MODE_SRAM: begin
                    if (cfg_bit) begin
                        trans   = T_ENTER_CACHE;
                        state_d = MODE_CACHE;
                    end
                end
                MODE_CACHE: begin
                    if (!cfg_bit) begin
                        trans   = T_LEAVE_CACHE;
                        state_d = MODE_SRAM;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_SRAM;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) inval <= 1'b0;
        else        inval <= (trans == T_LEAVE_CACHE);
    end

    assign mode_cache = (state_q == MODE_CACHE);

endmodule

// File: rtl/dmem_bank_decode.sv
module dmem_bank_decode #(
    parameter int ADDR_W    = 32,
    parameter int BANK_KB   = 32,
    parameter int LO_SELBIT = 14,
    parameter int HI_SELBIT = 23
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              mode_cache,
    input  logic              bsel_hi,
    output logic              bank_sel,
    output logic              cacheable
);

    localparam int HALF_BIT = $clog2(BANK_KB * 1024) - 1;

    logic chosen;

    generate
        if (LO_SELBIT == HI_SELBIT) begin : g_fixed
            assign chosen = acc_addr[LO_SELBIT];
        end else begin : g_mux
            assign chosen = bsel_hi ? acc_addr[HI_SELBIT] : acc_addr[LO_SELBIT];
        end
    endgenerate

    assign bank_sel  = mode_cache && chosen;
    assign cacheable = mode_cache && acc_addr[HALF_BIT];

endmodule

// File: rtl/dmem_bank_ctrl.sv
module dmem_bank_ctrl #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] CTRL_ADDR = 32'hFFE0_0004,
    parameter int          BANK_KB   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              lookaside_en,
    output logic              bank_cache_mode,
    output logic              bank_sel,
    output logic              acc_cacheable,
    output logic              inval_all
);

    logic hit_wr, cfg_bit, bsel_q;

    dmem_ctl_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .mode_cache(bank_cache_mode), .hit_wr(hit_wr),
        .cfg_bit(cfg_bit), .lae_q(lookaside_en), .bsel_q(bsel_q),
        .rdata(reg_rdata)
    );

    dmem_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit_wr(hit_wr), .cfg_bit(cfg_bit),
        .mode_cache(bank_cache_mode), .inval(inval_all)
    );

    dmem_bank_decode #(
        .ADDR_W(ADDR_W), .BANK_KB(BANK_KB), .LO_SELBIT(14), .HI_SELBIT(23)
    ) u_dec (
        .acc_addr(acc_addr), .mode_cache(bank_cache_mode), .bsel_hi(bsel_q),
        .bank_sel(bank_sel), .cacheable(acc_cacheable)
    );

endmodule

// File: rtl/dmem_bank_ctrl_chk.sv
module dmem_bank_ctrl_chk #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] CTRL_ADDR = 32'hFFE0_0004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              lookaside_en,
    input logic              bank_cache_mode,
    input logic              bank_sel,
    input logic              acc_cacheable,
    input logic              inval_all
);

    logic hit;
    assign hit = (reg_addr == CTRL_ADDR[ADDR_W-1:0]);

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (reg_rdata[0] && reg_rdata[12] && !reg_rdata[3])); // R5

    AST_SRAM_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_cache_mode |-> (!bank_sel && !acc_cacheable)); // R7

    AST_INVAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> !inval_all); // R10

    AST_INVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> ($past(bank_cache_mode) && !bank_cache_mode)); // R9

    AST_MODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_cache_mode != $past(bank_cache_mode)) |-> $past(reg_wr_en && hit)); // R4

    AST_LAE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr_en && hit) |-> $stable(lookaside_en)); // R3

endmodule

bind dmem_bank_ctrl dmem_bank_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .lookaside_en(lookaside_en),
    .bank_cache_mode(bank_cache_mode), .bank_sel(bank_sel),
    .acc_cacheable(acc_cacheable), .inval_all(inval_all)
);

// File: tb/dmem_bank_ctrl_bench.sv
module dmem_bank_ctrl_bench;

    localparam logic [31:0] CA = 32'hFFE0_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = '0;
    logic        lookaside_en, bank_cache_mode, bank_sel, acc_cacheable, inval_all;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dmem_bank_ctrl u_dmem_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
        .lookaside_en(lookaside_en), .bank_cache_mode(bank_cache_mode),
        .bank_sel(bank_sel), .acc_cacheable(acc_cacheable), .inval_all(inval_all)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write: drive at negedge, captured at next posedge, returns at following negedge
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = CA;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = CA;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic        prev_mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(CA, v);
        chk("R1 reset word", v, 32'h0000_1001);
        chk("R1 outputs", {27'd0, lookaside_en, bank_cache_mode, bank_sel, acc_cacheable, inval_all}, 32'd0);
        // R2 other address reads 0 and writes ignored
        rd(CA + 32'd4, v);
        chk("R2 miss read", v, 32'd0);
        wr(CA + 32'd4, 32'hFFFF_FFFF);
        rd(CA, v);
        chk("R2 miss write ignored", v, 32'h0000_1001);
        chk("R2 mode unchanged", {31'd0, bank_cache_mode}, 32'd0);

        prev_mode = 1'b0;
        for (int c = 0; c < 32; c++) begin
            logic lae, cfg, rsv, bs;
            logic [31:0] noise, d, exp_word;
            lae = c[0]; cfg = c[1]; rsv = c[2]; bs = c[3];
            noise = (c[4] ? 32'hFFFF_FFFF : 32'h5A5A_A5A4) & ~32'h0000_001E;
            d = noise | {27'd0, bs, rsv, cfg, lae, 1'b0};
            wr(CA, d);
            // R9 pulse in cycle after the write
            chk("R9 pulse", {31'd0, inval_all}, {31'd0, prev_mode & ~cfg});
            if (bank_cache_mode == 1'b0) begin
                // R7 during pulse cycle / SRAM mode
                acc_addr = 32'h0080_4000; #1;
                chk("R7 sram no select", {30'd0, bank_sel, acc_cacheable}, 32'd0);
            end
            exp_word = 32'h0000_1001 | {27'd0, bs, 1'b0, cfg, lae, 1'b0};
            rd(CA, v);
            chk("R3 R4 R5 readback", v, exp_word);
            chk("R3 lae out", {31'd0, lookaside_en}, {31'd0, lae});
            chk("R4 mode out", {31'd0, bank_cache_mode}, {31'd0, cfg});
            for (int a = 0; a < 4; a++) begin
                logic b14, b23;
                b14 = a[0]; b23 = a[1];
                acc_addr = 32'h1234_0AB0 & ~32'h0080_4000;
                acc_addr[14] = b14; acc_addr[23] = b23;
                #1;
                chk("R6 R7 bank_sel", {31'd0, bank_sel}, {31'd0, cfg & (bs ? b23 : b14)});
                chk("R8 cacheable", {31'd0, acc_cacheable}, {31'd0, cfg & b14});
            end
            @(negedge clk);
            chk("R9 pulse gone", {31'd0, inval_all}, 32'd0);
            prev_mode = cfg;
        end

        // R10 write during pulse cycle
        wr(CA, 32'h0000_0014);
        chk("R10 in cache", {31'd0, bank_cache_mode}, 32'd1);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = CA; reg_wdata = 32'h0000_0000;
        @(negedge clk);
        reg_wdata = 32'h0000_0014;
        chk("R10 pulse high", {31'd0, inval_all}, 32'd1);
        acc_addr = 32'h0080_4000; #1;
        chk("R10 sram in pulse cycle", {29'd0, bank_cache_mode, bank_sel, acc_cacheable}, 32'd0);
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R10 pulse one cycle", {31'd0, inval_all}, 32'd0);
        chk("R10 back to cache", {30'd0, bank_cache_mode, bank_sel}, 32'd3);
        @(negedge clk);
        chk("R9 no pulse entering cache", {31'd0, inval_all}, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule